// File: doc/BRIEF.md
# Prescaled Dual-Compare Event Timer

This block is one general-purpose timer channel. A slow reference enable, `ref_tick`, is divided by a power of two taken from a setup field. The divided tick advances a 16-bit up-counter. Two compare registers watch the counter. Each has a 2-bit mode field. One mode bit produces a one-cycle event strobe and sets a sticky status flag. The other mode bit sends the counter back to zero, so the channel runs as a periodic tick source.

Software reaches the channel through four word registers: setup, counter, compare A (CMP1) and compare B (CMP2). Reads are combinational. A periodic tick is set up in this order:
1. Load compare B with the period.
2. Write the counter to zero.
3. Write setup with the enable bit and mode 3 for compare B.

A setup-done bit claims the channel. After it is set, the prescale and mode fields are frozen until reset. The enable bit and the flag clears keep working.

The control part is a four-state machine, built from two choices: open or locked, and stopped or running.
- ST_OPEN_STOP: after reset, configurable and idle.
- ST_OPEN_RUN: configurable and counting.
- ST_LOCK_STOP: claimed and idle.
- ST_LOCK_RUN: claimed and counting.

Transitions happen only on a setup write:
- start: the enable bit is 1, so the machine goes from a STOP state to the RUN state of the same side.
- stop: the enable bit is 0, so the machine goes from RUN back to STOP.
- claim: the done bit is 1 in an OPEN state, so the machine goes to the LOCK state that the enable bit selects.

Only reset leaves the LOCK states.

Top module: `dcmp_timer`

## Requirements
- R1: After reset, all four registers read 0 and all strobes and flags are low. Reset also releases the setup lock.
- R2: The counter advances once every 2^s enabled reference ticks. s is setup bits 3:0. Values of s above 8 act as 8.
- R3: While the enable bit (setup bit 15) is 0, the counter holds its value and no strobe or flag is raised.
- R4: A write to address 1 loads the counter, even while the channel is running, and restarts the prescale phase.
- R5: Compare B (address 3) uses mode bits 9:8. Bit 8 enables its strobe and flag. Bit 9 sends a counter that equals compare B to 0 on the next tick. With mode 3 and period P, the counter cycles through 0..P and fires once every P+1 ticks.
- R6: Compare A (address 2) behaves like compare B, with mode bits 7:6.
- R7: When no restart applies, the counter rolls over from 0xFFFF to 0.
- R8: A strobe is high for the one cycle after the clock edge that carries a tick on which the counter held that compare value.
- R9: Flag A (setup bit 13) and flag B (setup bit 14) stay set until a setup write has a 1 in that bit. Writing 0 there leaves the flag set. A new match in the same cycle as a clear wins.
- R10: Once setup bit 12 (done) is written as 1, the scale, both mode fields and the done bit ignore writes until reset. Enable and the flag clears stay writable.
- R11: Address map: 0 setup, 1 counter, 2 compare A, 3 compare B. A read returns the current register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ref_tick | input | 1 | Slow reference enable, one pulse per reference period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| cmp1_evt | output | 1 | Compare A event strobe |
| cmp2_evt | output | 1 | Compare B event strobe |
| cmp1_flag | output | 1 | Compare A sticky flag |
| cmp2_flag | output | 1 | Compare B sticky flag |

## Verification
A register write takes effect at the clock edge that samples it. Reads are combinational. The bench therefore drives and reads at the falling edge, one full cycle after the write. Strobes and flags are registered and are due in the cycle that follows the edge carrying the divided tick. The bench counts strobes at every falling edge while `ref_tick` is held high, so each strobe is seen exactly once. Counter values and strobe counts are computed arithmetically from the number of reference ticks, the scale, the period and the compare value. These are swept over several scales and periods.

// File: rtl/dcmp_pkg.sv
package dcmp_pkg;
    localparam int SCL_W  = 4;
    localparam int B_EN   = 15;
    localparam int B_FLGB = 14;
    localparam int B_FLGA = 13;
    localparam int B_DONE = 12;

    typedef enum logic [1:0] {
        ST_OPEN_STOP = 2'b00,
        ST_OPEN_RUN  = 2'b01,
        ST_LOCK_STOP = 2'b10,
        ST_LOCK_RUN  = 2'b11
    } ctl_state_t;

    typedef struct packed {
        logic [1:0]       mode_b;
        logic [1:0]       mode_a;
        logic [SCL_W-1:0] scale;
    } cfg_t;
endpackage

// File: rtl/dcmp_ctrl.sv
module dcmp_ctrl
    import dcmp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic setup_wr,
    input  logic en_bit,
    input  logic done_bit,
    input  cfg_t new_cfg,
    output cfg_t cfg,
    output logic run,
    output logic locked
);
    ctl_state_t st_q, st_d;
    cfg_t       cfg_q;

    always_comb begin
        st_d = st_q;
        if (setup_wr) begin
            unique case (st_q)
                ST_OPEN_STOP, ST_OPEN_RUN:
                    if (done_bit) st_d = en_bit ? ST_LOCK_RUN : ST_LOCK_STOP;
                    else          st_d = en_bit ? ST_OPEN_RUN : ST_OPEN_STOP;
                ST_LOCK_STOP, ST_LOCK_RUN:
                    st_d = en_bit ? ST_LOCK_RUN : ST_LOCK_STOP;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OPEN_STOP;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cfg_q <= '0;
        else if (setup_wr && !locked)   cfg_q <= new_cfg;
    end

    always_comb begin
        run    = (st_q == ST_OPEN_RUN) || (st_q == ST_LOCK_RUN);
        locked = (st_q == ST_LOCK_STOP) || (st_q == ST_LOCK_RUN);
        cfg    = cfg_q;
    end
endmodule

// File: rtl/dcmp_presc.sv
module dcmp_presc
    import dcmp_pkg::*;
#(
    parameter int SCALE_MAX = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             ref_tick,
    input  logic [SCL_W-1:0] scale,
    output logic             tick
);
    localparam int PRE_W = (SCALE_MAX < 1) ? 1 : SCALE_MAX;

    logic [SCL_W-1:0] eff;
    logic [PRE_W-1:0] limit, pre_q;

    always_comb begin
        eff   = (scale > SCL_W'(SCALE_MAX)) ? SCL_W'(SCALE_MAX) : scale;
        limit = PRE_W'((32'd1 << eff) - 32'd1);
        tick  = run && ref_tick && (pre_q == limit);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 pre_q <= '0;
        else if (!run || restart)   pre_q <= '0;
        else if (ref_tick)          pre_q <= (pre_q == limit) ? '0 : pre_q + 1'b1;
    end
endmodule

// File: rtl/dcmp_cmp.sv
module dcmp_cmp #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             tick,
    input  logic [CNT_W-1:0] cnt,
    input  logic [1:0]       mode,
    input  logic             clr_flag,
    output logic [CNT_W-1:0] cmp_val,
    output logic             hit_restart,
    output logic             evt,
    output logic             flag
);
    logic [CNT_W-1:0] cmp_q;
    logic             hit;

    always_comb begin
        hit         = tick && (cnt == cmp_q);
        hit_restart = hit && mode[1];
        cmp_val     = cmp_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmp_q <= '0;
            evt   <= 1'b0;
            flag  <= 1'b0;
        end else begin
            if (cmp_wr) cmp_q <= wdata;
            evt <= hit && mode[0];
            if (hit && mode[0]) flag <= 1'b1;
            else if (clr_flag)  flag <= 1'b0;
        end
    end
endmodule

// File: rtl/dcmp_timer.sv
module dcmp_timer
    import dcmp_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SCALE_MAX = 8,
    parameter int N_CMP     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             reg_wr,
    input  logic [1:0]       reg_addr,
    input  logic [CNT_W-1:0] reg_wdata,
    output logic [CNT_W-1:0] reg_rdata,
    output logic             cmp1_evt,
    output logic             cmp2_evt,
    output logic             cmp1_flag,
    output logic             cmp2_flag
);
    cfg_t             cfg, new_cfg;
    logic             run, locked, tick, setup_wr, cnt_wr;
    logic [CNT_W-1:0] cnt_q;
    logic [N_CMP-1:0] cmp_wr, clr, hit_rst, evt, flag;
    logic [1:0]       mode [N_CMP];
    logic [CNT_W-1:0] cmp_val [N_CMP];
    logic [15:0]      setup_rd;

    always_comb begin
        setup_wr = reg_wr && (reg_addr == 2'd0);
        cnt_wr   = reg_wr && (reg_addr == 2'd1);
        new_cfg  = '{mode_b: reg_wdata[9:8], mode_a: reg_wdata[7:6],
                     scale: reg_wdata[SCL_W-1:0]};
        mode[0]  = cfg.mode_a;
        mode[1]  = cfg.mode_b;
        clr[0]   = setup_wr && reg_wdata[B_FLGA];
        clr[1]   = setup_wr && reg_wdata[B_FLGB];
    end

    dcmp_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .setup_wr(setup_wr),
        .en_bit(reg_wdata[B_EN]), .done_bit(reg_wdata[B_DONE]),
        .new_cfg(new_cfg), .cfg(cfg), .run(run), .locked(locked)
    );

    dcmp_presc #(.SCALE_MAX(SCALE_MAX)) u_presc (
        .clk(clk), .rst_n(rst_n), .run(run), .restart(cnt_wr),
        .ref_tick(ref_tick), .scale(cfg.scale), .tick(tick)
    );

    for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
        assign cmp_wr[g] = reg_wr && (reg_addr == 2'(g + 2));
        dcmp_cmp #(.CNT_W(CNT_W)) u_cmp (
            .clk(clk), .rst_n(rst_n), .cmp_wr(cmp_wr[g]), .wdata(reg_wdata),
            .tick(tick), .cnt(cnt_q), .mode(mode[g]), .clr_flag(clr[g]),
            .cmp_val(cmp_val[g]), .hit_restart(hit_rst[g]),
            .evt(evt[g]), .flag(flag[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (cnt_wr)  cnt_q <= reg_wdata;
        else if (tick)    cnt_q <= (|hit_rst) ? '0 : cnt_q + 1'b1;
    end

    always_comb begin
        setup_rd = {run, flag[1], flag[0], locked, 2'b00, cfg.mode_b,
                    cfg.mode_a, 2'b00, cfg.scale};
        unique case (reg_addr)
            2'd0: reg_rdata = CNT_W'(setup_rd);
            2'd1: reg_rdata = cnt_q;
            2'd2: reg_rdata = cmp_val[0];
            2'd3: reg_rdata = cmp_val[1];
        endcase
        cmp1_evt  = evt[0];
        cmp2_evt  = evt[1];
        cmp1_flag = flag[0];
        cmp2_flag = flag[1];
    end
endmodule

// File: rtl/dcmp_timer_chk.sv
module dcmp_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ref_tick,
    input logic             cnt_wr,
    input logic             tick,
    input logic             run,
    input logic             locked,
    input logic             clr_b,
    input logic             cmp2_evt,
    input logic             cmp2_flag,
    input logic [CNT_W-1:0] cnt,
    input logic [7:0]       cfg_bits
);
    // R2: the counter moves only on a divided tick or a counter write
    a_r2_cnt_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    // R3: a stopped channel holds its count
    a_r3_stop_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr) |=> $stable(cnt));

    // R8: a strobe follows an edge that saw a reference tick
    a_r8_evt_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
        cmp2_evt |-> $past(ref_tick));

    // R9: a flag only drops through a clear write
    a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp2_flag && !clr_b) |=> cmp2_flag);

    // R5: a rising flag comes with its strobe
    a_r5_flag_with_evt: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmp2_flag) |-> cmp2_evt);

    // R10: once claimed, the channel stays claimed and its config is frozen
    a_r10_lock_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> (locked && $stable(cfg_bits)));
endmodule

bind dcmp_timer dcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cnt_wr(cnt_wr),
    .tick(tick), .run(run), .locked(locked), .clr_b(clr[1]),
    .cmp2_evt(cmp2_evt), .cmp2_flag(cmp2_flag), .cnt(cnt_q),
    .cfg_bits(cfg)
);

// File: tb/dcmp_timer_tb_top.sv
`timescale 1ns/1ps
module dcmp_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        cmp1_evt, cmp2_evt, cmp1_flag, cmp2_flag;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    dcmp_timer dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .cmp1_evt(cmp1_evt), .cmp2_evt(cmp2_evt),
        .cmp1_flag(cmp1_flag), .cmp2_flag(cmp2_flag)
    );

    function automatic logic [15:0] mk(input bit en, input bit done,
            input int mb, input int ma, input int s, input bit cb, input bit ca);
        logic [15:0] w;
        w = '0;
        w[15] = en; w[14] = cb; w[13] = ca; w[12] = done;
        w[9:8] = 2'(mb); w[7:6] = 2'(ma); w[3:0] = 4'(s);
        return w;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'(a); reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        reg_addr = 2'(a);
        #1;
        v = int'(reg_rdata);
    endtask

    task automatic run_ticks(input int n, output int ca, output int cb);
        ca = 0; cb = 0;
        ref_tick = 1'b1;
        repeat (n) begin
            @(negedge clk);
            ca += int'(cmp1_evt);
            cb += int'(cmp2_evt);
        end
        ref_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int v, ca, cb, t, ea, eb, c;
        do_reset();

        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(a, v);
            check(v == 0, "R1 reset register", v, 0);
        end
        check({cmp1_evt, cmp2_evt, cmp1_flag, cmp2_flag} == 4'b0, "R1 outputs", 1, 0);

        // R2 R5 R6 R8 sweep: scale, period, compare A midpoint
        for (int s = 0; s < 3; s++) begin
            for (int p = 0; p < 5; p++) begin
                c = p / 2;
                wr(0, mk(0, 0, 3, 1, s, 1, 1));
                wr(2, 16'(c));
                wr(3, 16'(p));
                wr(1, 16'd0);
                wr(0, mk(1, 0, 3, 1, s, 1, 1));
                run_ticks(24, ca, cb);
                t  = 24 >> s;
                eb = t / (p + 1);
                ea = 0;
                for (int k = 1; k <= t; k++) if (((k - 1) % (p + 1)) == c) ea++;
                rd(1, v);
                check(v == t % (p + 1), "R2/R5 counter after sweep", v, t % (p + 1));
                check(cb == eb, "R5/R8 compare B strobe count", cb, eb);
                check(ca == ea, "R6/R8 compare A strobe count", ca, ea);
                check(cmp2_flag == (eb > 0), "R5 compare B flag", int'(cmp2_flag), int'(eb > 0));
            end
        end

        // R7: free rollover with no restart
        wr(0, mk(0, 0, 0, 0, 0, 1, 1));
        wr(1, 16'hFFFD);
        wr(0, mk(1, 0, 0, 0, 0, 0, 0));
        run_ticks(4, ca, cb);
        rd(1, v);
        check(v == 1, "R7 rollover", v, 1);
        check(ca + cb == 0, "R7 no strobes with modes off", ca + cb, 0);

        // R4: load while running
        wr(1, 16'h0100);
        rd(1, v);
        check(v == 16'h0100, "R4 load while running", v, 16'h0100);
        run_ticks(3, ca, cb);
        rd(1, v);
        check(v == 16'h0103, "R4 count after load", v, 16'h0103);

        // R3: stopped channel ignores ticks
        wr(0, mk(0, 0, 3, 3, 0, 0, 0));
        run_ticks(10, ca, cb);
        rd(1, v);
        check(v == 16'h0103, "R3 counter held while stopped", v, 16'h0103);
        check(ca + cb == 0, "R3 no strobes while stopped", ca + cb, 0);
        rd(0, v);
        check(v[15] == 1'b0, "R3 enable reads 0", v, 0);

        // R2: scale above 8 acts as 8
        wr(0, mk(0, 0, 0, 0, 9, 0, 0));
        wr(1, 16'd0);
        wr(0, mk(1, 0, 0, 0, 9, 0, 0));
        run_ticks(600, ca, cb);
        rd(1, v);
        check(v == 2, "R2 scale clamp", v, 2);

        // R9: sticky flag, write-one-to-clear
        wr(0, mk(0, 0, 1, 0, 0, 1, 1));
        wr(3, 16'd2);
        wr(1, 16'd0);
        wr(0, mk(1, 0, 1, 0, 0, 1, 1));
        run_ticks(5, ca, cb);
        rd(1, v);
        check(v == 5, "R9 no restart with mode 1", v, 5);
        check(cb == 1, "R9 one strobe", cb, 1);
        repeat (3) @(negedge clk);
        rd(0, v);
        check(v[14] == 1'b1 && cmp2_flag, "R9 flag sticky", v, 16'h4000);
        wr(0, mk(1, 0, 1, 0, 0, 0, 0));
        check(cmp2_flag == 1'b1, "R9 writing 0 keeps flag", int'(cmp2_flag), 1);
        wr(0, mk(1, 0, 1, 0, 0, 1, 0));
        check(cmp2_flag == 1'b0, "R9 write one clears flag", int'(cmp2_flag), 0);

        // R11: compare readback
        rd(3, v);
        check(v == 2, "R11 compare B readback", v, 2);
        wr(2, 16'hA5C3);
        rd(2, v);
        check(v == 16'hA5C3, "R11 compare A readback", v, 16'hA5C3);

        // R10: lock
        wr(0, mk(0, 1, 3, 0, 2, 0, 0));
        wr(1, 16'd0);
        wr(0, mk(1, 0, 0, 1, 5, 0, 0));
        rd(0, v);
        check(v == int'(mk(1, 1, 3, 0, 2, 0, 0)), "R10 frozen fields, enable writable",
              v, int'(mk(1, 1, 3, 0, 2, 0, 0)));
        run_ticks(8, ca, cb);
        rd(1, v);
        check(v == 2, "R10 locked scale in effect", v, 2);

        // R1: reset releases the lock
        do_reset();
        wr(0, mk(0, 0, 0, 0, 1, 0, 0));
        rd(0, v);
        check(v == 1, "R1 lock released by reset", v, 1);

        finish_run();
    end
endmodule